// File: doc/BRIEF.md
# Charge-Pump Switch Phase Sequencer

This block drives the gate enables of a 1.5x switched-capacitor boost built from seven switches split into two unequal groups. The charge group (three switches) connects both flying capacitors across the supply. The transfer group (four switches) stacks the charged capacitors on top of the supply to feed the boosted rail. The block alternates the two groups with a programmable dead gap between them. At the 50 MHz default it runs a 46-cycle period, about 1.09 MHz. Current limiting and the regulation comparators are outside the block.

After enable it holds a current-limit request (`softStart`) for a timed window, nominally 1.2 ms, and then raises `ready`. When the supply is above the high-supply threshold and the external overvoltage comparator is tripped, whole transfer pulses are skipped. The comparator provides the hysteresis, so the boosted rail is held near its ceiling. Dropping enable turns both groups off in the same cycle and clears the soft-start timer.

Top module: `cpPhaseSeq`

## Requirements
- R1: `chargeEn` and `transferEn` are never high in the same cycle.
- R2: After enable is first sampled high on a clock edge, `chargeEn` is high for exactly PHASE_CYC cycles. The sequence then repeats a dead gap, a transfer slot of PHASE_CYC cycles, another dead gap, and the next charge slot.
- R3: Each dead gap lasts `deadCycles` cycles, and a value of 0 is treated as 1, so `transferEn` is low in the cycle after `chargeEn` falls.
- R4: While `enable` is low, both switch enables are low, with no clock edge needed. Re-enabling restarts the sequence with a charge slot.
- R5: `softStart` is high from enable until SOFT_CYC clock edges have sampled enable high. `ready` then replaces it. Both are low while disabled.
- R6: Deasserting enable clears the soft-start timer, so a new enable gives a full new window.
- R7: A transfer slot is skipped (`transferEn` stays low for the whole slot) when `vddHigh` and `ovpFlag` are both high at the edge that starts the slot. Charge slots and timing are not affected.
- R8: Either `vddHigh` or `ovpFlag` alone does not skip a transfer slot.
- R9: A change of `ovpFlag` inside a slot does not shorten or revive that slot. It takes effect from the next transfer slot.
- R10: While reset is held with enable low, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run request; low forces both groups off |
| vddHigh | input | 1 | Supply is above the high-supply threshold |
| ovpFlag | input | 1 | Boosted rail is above the overvoltage level |
| deadCycles | input | DEAD_W | Dead gap length in cycles (0 acts as 1) |
| chargeEn | output | 1 | Charge group switch enable (three switches) |
| transferEn | output | 1 | Transfer group switch enable (four switches) |
| softStart | output | 1 | Current-limit request during soft start |
| ready | output | 1 | Soft start finished while enabled |

## Verification
The bench builds the block with PHASE_CYC=3, SOFT_CYC=20 and DEAD_W=4. With these values a full switching period fits in at most 36 cycles, and the end of soft start falls after 20 edges. This lets every dead value from 0 to the 4-bit maximum of 15 be observed over several periods. It also lets the exact edge where `ready` takes over be checked directly. The short slots let the bench toggle the overvoltage flag inside one chosen transfer slot and watch the slot that follows.

// File: rtl/cpSeqPkg.sv
package cpSeqPkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CHARGE,
    PH_GAP_AB,
    PH_XFER,
    PH_GAP_BA
  } phaseE;

  typedef struct packed {
    logic loadSlot;
    logic loadGap;
    logic ssRun;
  } seqStrobeT;

endpackage

// File: rtl/cpSeqDatapath.sv
module cpSeqDatapath
  import cpSeqPkg::*;
#(
  parameter int PHASE_CYC = 22,
  parameter int SOFT_CYC  = 60000,
  parameter int DEAD_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobeT         strobe,
  input  logic [DEAD_W-1:0] deadCycles,
  output logic              slotDone,
  output logic              softDone
);

  localparam int SLOT_W = $clog2(PHASE_CYC + 1);
  localparam int CNT_W  = (SLOT_W > DEAD_W) ? SLOT_W : DEAD_W;
  localparam int SS_W   = $clog2(SOFT_CYC + 1);

  logic [CNT_W-1:0] slotCnt;
  logic [CNT_W-1:0] gapLoad;
  logic [SS_W-1:0]  ssCnt;

  // a zero dead setting still yields one idle cycle
  assign gapLoad = (deadCycles == '0) ? '0 : (CNT_W'(deadCycles) - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotCnt <= '0;
    end else if (strobe.loadSlot) begin
      slotCnt <= CNT_W'(PHASE_CYC - 1);
    end else if (strobe.loadGap) begin
      slotCnt <= gapLoad;
    end else if (slotCnt != '0) begin
      slotCnt <= slotCnt - CNT_W'(1);
    end
  end

  assign slotDone = (slotCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ssCnt <= '0;
    end else if (!strobe.ssRun) begin
      ssCnt <= '0;
    end else if (ssCnt != SS_W'(SOFT_CYC)) begin
      ssCnt <= ssCnt + SS_W'(1);
    end
  end

  assign softDone = (ssCnt == SS_W'(SOFT_CYC));

  // R5: once finished, soft start stays finished while running
  assert_soft_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (softDone && strobe.ssRun) |=> softDone);

  // R6: a stop clears the timer
  assert_soft_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.ssRun |=> !softDone);

endmodule

// File: rtl/cpSeqControl.sv
module cpSeqControl
  import cpSeqPkg::*;
#(
  parameter int PHASE_CYC = 22
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      vddHigh,
  input  logic      ovpFlag,
  input  logic      slotDone,
  output seqStrobeT strobe,
  output logic      chargeEn,
  output logic      transferEn
);

  phaseE phase;
  logic  skipXfer;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      skipXfer <= 1'b0;
    end else if (!enable) begin
      phase    <= PH_IDLE;
      skipXfer <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE:   phase <= PH_CHARGE;
        PH_CHARGE: if (slotDone) phase <= PH_GAP_AB;
        PH_GAP_AB: if (slotDone) begin
                     phase    <= PH_XFER;
                     skipXfer <= vddHigh & ovpFlag;
                   end
        PH_XFER:   if (slotDone) phase <= PH_GAP_BA;
        PH_GAP_BA: if (slotDone) phase <= PH_CHARGE;
        default:   phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.ssRun    = enable;
    strobe.loadSlot = enable && ((phase == PH_IDLE) ||
                      (slotDone && (phase == PH_GAP_AB || phase == PH_GAP_BA)));
    strobe.loadGap  = enable && slotDone &&
                      (phase == PH_CHARGE || phase == PH_XFER);
  end

  assign chargeEn   = enable && (phase == PH_CHARGE);
  assign transferEn = enable && (phase == PH_XFER) && !skipXfer;

  assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(chargeEn && transferEn));

  assert_gap_after_charge_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(chargeEn) |-> !transferEn);

  assert_gap_after_xfer_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(transferEn) |-> !chargeEn);

  // R2, R4: first edge with enable high starts a charge slot
  assert_start_charge_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enable) |=> (chargeEn || !enable));

  generate
    if (PHASE_CYC > 1) begin : g_holdChk
      // R9: a transfer pulse, once started, is not cut short by the flag
      assert_xfer_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
        $rose(transferEn) |=> (transferEn || !enable));
    end
  endgenerate

endmodule

// File: rtl/cpPhaseSeq.sv
module cpPhaseSeq
  import cpSeqPkg::*;
#(
  parameter int PHASE_CYC = 22,
  parameter int SOFT_CYC  = 60000,
  parameter int DEAD_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              vddHigh,
  input  logic              ovpFlag,
  input  logic [DEAD_W-1:0] deadCycles,
  output logic              chargeEn,
  output logic              transferEn,
  output logic              softStart,
  output logic              ready
);

  seqStrobeT strobe;
  logic      slotDone;
  logic      softDone;

  cpSeqControl #(.PHASE_CYC(PHASE_CYC)) i_control (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .vddHigh    (vddHigh),
    .ovpFlag    (ovpFlag),
    .slotDone   (slotDone),
    .strobe     (strobe),
    .chargeEn   (chargeEn),
    .transferEn (transferEn)
  );

  cpSeqDatapath #(
    .PHASE_CYC (PHASE_CYC),
    .SOFT_CYC  (SOFT_CYC),
    .DEAD_W    (DEAD_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .deadCycles (deadCycles),
    .slotDone   (slotDone),
    .softDone   (softDone)
  );

  assign softStart = enable && !softDone;
  assign ready     = enable && softDone;

  assert_ready_needs_enable_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> $past(enable));

endmodule

// File: tb/test_cpPhaseSeq.sv
module test_cpPhaseSeq;

  localparam int P    = 3;
  localparam int SS   = 20;
  localparam int DW   = 4;
  localparam int WIN  = 64;

  // fields: dead[10:7] vddHigh[6] ovp[5] expGap[4:1] expSkip[0]
  localparam logic [10:0] VEC [0:6] = '{
    {4'd1,  1'b0, 1'b0, 4'd1,  1'b0},
    {4'd0,  1'b0, 1'b0, 4'd1,  1'b0},
    {4'd2,  1'b1, 1'b0, 4'd2,  1'b0},
    {4'd5,  1'b0, 1'b1, 4'd5,  1'b0},
    {4'd3,  1'b1, 1'b1, 4'd3,  1'b1},
    {4'd7,  1'b0, 1'b0, 4'd7,  1'b0},
    {4'd15, 1'b1, 1'b0, 4'd15, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic vddHigh = 1'b0;
  logic ovpFlag = 1'b0;
  logic [DW-1:0] deadCycles = '0;
  logic chargeEn, transferEn, softStart, ready;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;
  logic aS [WIN];
  logic bS [WIN];

  always #10 clk = ~clk;

  cpPhaseSeq #(.PHASE_CYC(P), .SOFT_CYC(SS), .DEAD_W(DW)) i_cpPhaseSeq (
    .clk(clk), .rstN(rstN), .enable(enable), .vddHigh(vddHigh),
    .ovpFlag(ovpFlag), .deadCycles(deadCycles), .chargeEn(chargeEn),
    .transferEn(transferEn), .softStart(softStart), .ready(ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic restart();
    enable = 1'b0;
    tick();
    enable = 1'b1;
  endtask

  initial begin
    #(20 * 20000);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    int aw, gap, bw, bTot, ovl, idx, e, mA, mB;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!chargeEn && !transferEn && !softStart && !ready, "R10", 
        {chargeEn, transferEn, softStart, ready}, 0);
    rstN = 1'b1;
    tick();

    // vector table: R1 R2 R3 R7 R8
    for (int v = 0; v < 7; v++) begin
      enable = 1'b0;
      tick();
      deadCycles = VEC[v][10:7];
      vddHigh    = VEC[v][6];
      ovpFlag    = VEC[v][5];
      enable     = 1'b1;
      for (int i = 0; i < WIN; i++) begin
        tick();
        aS[i] = chargeEn;
        bS[i] = transferEn;
      end
      aw = 0; ovl = 0; bTot = 0;
      for (int i = 0; i < WIN; i++) begin
        if (aS[i] && bS[i]) ovl++;
        if (bS[i]) bTot++;
      end
      for (int i = 0; i < WIN; i++) begin
        if (!aS[i]) break;
        aw++;
      end
      chk(ovl == 0, "R1", ovl, 0);
      chk(aw == P, "R2", aw, P);
      e = 2 * P + 2 * int'(VEC[v][4:1]);
      chk(aS[e] && !aS[e-1], "R2", int'(aS[e]), 1);
      if (VEC[v][0]) begin
        chk(bTot == 0, "R7", bTot, 0);
      end else begin
        gap = 0; idx = aw;
        while (idx < WIN && !bS[idx] && !aS[idx]) begin gap++; idx++; end
        bw = 0;
        while (idx < WIN && bS[idx]) begin bw++; idx++; end
        chk(gap == int'(VEC[v][4:1]), "R3", gap, int'(VEC[v][4:1]));
        chk(bw == P, (VEC[v][6] || VEC[v][5]) ? "R8" : "R2", bw, P);
      end
    end

    // soft start window R5
    enable = 1'b0; vddHigh = 1'b0; ovpFlag = 1'b0; deadCycles = 4'd1;
    tick();
    enable = 1'b1;
    #1;
    chk(softStart && !ready, "R5", {softStart, ready}, 2);
    repeat (SS - 1) tick();
    chk(softStart && !ready, "R5", {softStart, ready}, 2);
    tick();
    chk(!softStart && ready, "R5", {softStart, ready}, 1);
    enable = 1'b0;
    #1;
    chk(!softStart && !ready, "R5", {softStart, ready}, 0);
    // R6: timer cleared by the stop
    tick();
    enable = 1'b1;
    repeat (SS - 1) tick();
    chk(softStart && !ready, "R6", {softStart, ready}, 2);

    // R4: disable inside a charge slot and inside a transfer slot
    restart();
    tick();
    chk(chargeEn, "R4", chargeEn, 1);
    enable = 1'b0;
    #1;
    chk(!chargeEn && !transferEn, "R4", chargeEn, 0);
    tick();
    enable = 1'b1;
    repeat (P + 2) tick();
    chk(transferEn, "R4", transferEn, 1);
    enable = 1'b0;
    #1;
    chk(!transferEn && !chargeEn, "R4", transferEn, 0);
    tick();
    enable = 1'b1;
    tick();
    chk(chargeEn, "R4", chargeEn, 1);

    // R9: flag changes inside slots; dead=1 so the period is 8
    restart();
    vddHigh = 1'b1; ovpFlag = 1'b0;
    mA = 0; mB = 0;
    for (int i = 0; i < 24; i++) begin
      bit expA, expB;
      tick();
      expA = (i % 8) < P;
      expB = (i >= 4 && i <= 6) || (i >= 20 && i <= 22);
      if (chargeEn != expA) mA++;
      if (transferEn != expB) mB++;
      if (i == 4)  ovpFlag = 1'b1;
      if (i == 13) ovpFlag = 1'b0;
    end
    chk(mB == 0, "R9", mB, 0);
    chk(mA == 0, "R7", mA, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule